// File: doc/BRIEF.md
# Steered-Adder Arithmetic Unit

This block is a purely combinational arithmetic unit that performs eight operations on two small operands, every one of them through a single ripple-carry adder. Operand A always feeds the adder's first input. A two-level tree of 2:1 multiplexers chooses the adder's second input from four options: B, the bitwise complement of B, all zeros or all ones. The lowest opcode bit is wired straight to the adder's carry-in.

With this arrangement one adder covers several operations:

- addition, with or without an added 1;
- two's-complement subtraction, with or without a borrow;
- increment and decrement of A;
- transfer of A, which can be reached in two ways.

The block also reports an unsigned carry-out, a signed overflow flag and a zero flag. Opcode bit 3 is reserved and has no effect on any output. The block has no clock. It sits between operand sources and a result consumer, and its outputs settle as soon as its inputs change.

Top module: `steer_alu`

## Requirements
- R1: Opcode bits [2:0] = 000 yields res = (A + B) mod 2^W, where W is the data width (default 4).
- R2: Opcode bits [2:0] = 001 yields res = (A + B + 1) mod 2^W.
- R3: Opcode bits [2:0] = 010 yields res = (A - B - 1) mod 2^W, formed as A plus the complement of B.
- R4: Opcode bits [2:0] = 011 yields res = (A - B) mod 2^W, and carry_out is 1 exactly when A >= B as unsigned numbers.
- R5: Opcode bits [2:0] = 100 and 111 both yield res = A. carry_out is 0 for 100 and 1 for 111.
- R6: Opcode bits [2:0] = 101 yields res = (A + 1) mod 2^W, and 110 yields res = (A - 1) mod 2^W.
- R7: carry_out equals bit W of the unsigned sum A + Y + op_sel[0]. Y is B for op_sel[2:1] = 00, ~B for 01, all zeros for 10 and all ones for 11.
- R8: ovf is 1 exactly when the signed two's-complement value of A + Y + op_sel[0] lies outside the range -2^(W-1) to 2^(W-1)-1.
- R9: zero is 1 if and only if every bit of res is 0.
- R10: op_sel[3] is reserved. With it set, res, carry_out, ovf and zero equal the values for the same op_sel[2:0] with it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Opcode. Bit 0 is the carry-in, bits 2:1 steer the second adder input, bit 3 is reserved |
| opnd_a | input | W | First operand, always the adder's first input |
| opnd_b | input | W | Second operand |
| res | output | W | Adder sum |
| carry_out | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | High when res is all zeros |

## Verification
The bench builds the unit with the default width of 4. At that width, all 16 opcodes, including those with the reserved bit set, combined with all 256 operand pairs make 4096 input combinations, and the bench applies every one of them. Each combination is checked against arithmetic computed in the bench. That arithmetic works with plain integers for the unsigned carry and with signed integers for overflow, so every wrap point, borrow boundary and sign-crossing case is exercised.

// File: rtl/steer_alu_pkg.sv
package steer_alu_pkg;
  localparam int OPW          = 4;
  localparam int OP_CIN_BIT   = 0;
  localparam int OP_INV_BIT   = 1;
  localparam int OP_CONST_BIT = 2;
  localparam int OP_RSVD_BIT  = 3;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NB   = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/steer_alu_fa_cell.sv
module steer_alu_fa_cell (
  input  logic a_in,
  input  logic b_in,
  input  logic c_in,
  output logic s_out,
  output logic c_out
);
  logic half_x;

  assign half_x = a_in ^ b_in;
  assign s_out  = half_x ^ c_in;
  assign c_out  = (a_in & b_in) | (half_x & c_in);

  always_comb begin
    AST_FA_COUNT: assert ({c_out, s_out} == 2'(a_in) + 2'(b_in) + 2'(c_in)); // R7
  end
endmodule

// File: rtl/steer_alu_ripple.sv
module steer_alu_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W:0]   carry_vec
);
  assign carry_vec[0] = cin;

  for (genvar gi = 0; gi < W; gi++) begin : g_cell
    steer_alu_fa_cell u_fa (
      .a_in  (x_in[gi]),
      .b_in  (y_in[gi]),
      .c_in  (carry_vec[gi]),
      .s_out (sum[gi]),
      .c_out (carry_vec[gi+1])
    );
  end

  always_comb begin
    AST_RIPPLE_TOTAL: assert ({carry_vec[W], sum} == (W+1)'(x_in) + (W+1)'(y_in) + (W+1)'(cin)); // R7
  end
endmodule

// File: rtl/steer_alu_mux2.sv
module steer_alu_mux2 #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] q
);
  always_comb begin
    if (sel) q = d1;
    else     q = d0;
  end
endmodule

// File: rtl/steer_alu_ysel.sv
module steer_alu_ysel #(
  parameter int W = 4
) (
  input  logic         sel_const,
  input  logic         sel_inv,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] y_out
);
  localparam logic [W-1:0] ALL_ZERO = '0;
  localparam logic [W-1:0] ALL_ONE  = '1;

  logic [W-1:0] leg_plain;
  logic [W-1:0] leg_inv;

  // First level, selected by the constant bit: B or zeros, ~B or ones.
  steer_alu_mux2 #(.W(W)) u_lvl_plain (
    .sel (sel_const),
    .d0  (b_in),
    .d1  (ALL_ZERO),
    .q   (leg_plain)
  );

  steer_alu_mux2 #(.W(W)) u_lvl_inv (
    .sel (sel_const),
    .d0  (~b_in),
    .d1  (ALL_ONE),
    .q   (leg_inv)
  );

  // Second level, selected by the invert bit, drives the adder.
  steer_alu_mux2 #(.W(W)) u_lvl_out (
    .sel (sel_inv),
    .d0  (leg_plain),
    .d1  (leg_inv),
    .q   (y_out)
  );

  always_comb begin
    AST_YSEL_CONST: assert (!sel_const || y_out == (sel_inv ? ALL_ONE : ALL_ZERO)); // R7
    AST_YSEL_BVAL: assert (sel_const || (y_out ^ b_in) == (sel_inv ? ALL_ONE : ALL_ZERO)); // R7
  end
endmodule

// File: rtl/steer_alu_flags.sv
module steer_alu_flags #(
  parameter int W = 4
) (
  input  logic [W-1:0] sum,
  input  logic [W:0]   carry_vec,
  output logic         c_flag,
  output logic         v_flag,
  output logic         z_flag
);
  assign c_flag = carry_vec[W];
  assign v_flag = carry_vec[W] ^ carry_vec[W-1];
  assign z_flag = ~|sum;

  always_comb begin
    AST_ZERO_MATCH: assert (z_flag == (sum == '0)); // R9
  end
endmodule

// File: rtl/steer_alu.sv
module steer_alu #(
  parameter int W = 4
) (
  input  logic [steer_alu_pkg::OPW-1:0] op_sel,
  input  logic [W-1:0]                  opnd_a,
  input  logic [W-1:0]                  opnd_b,
  output logic [W-1:0]                  res,
  output logic                          carry_out,
  output logic                          ovf,
  output logic                          zero
);
  import steer_alu_pkg::*;

  logic [W-1:0] adder_y;
  logic [W:0]   carries;

  steer_alu_ysel #(.W(W)) u_ysel (
    .sel_const (op_sel[OP_CONST_BIT]),
    .sel_inv   (op_sel[OP_INV_BIT]),
    .b_in      (opnd_b),
    .y_out     (adder_y)
  );

  steer_alu_ripple #(.W(W)) u_adder (
    .x_in      (opnd_a),
    .y_in      (adder_y),
    .cin       (op_sel[OP_CIN_BIT]),
    .sum       (res),
    .carry_vec (carries)
  );

  steer_alu_flags #(.W(W)) u_flags (
    .sum       (res),
    .carry_vec (carries),
    .c_flag    (carry_out),
    .v_flag    (ovf),
    .z_flag    (zero)
  );

  always_comb begin
    AST_NO_OVERFLOW: assert (ovf == ((opnd_a[W-1] == adder_y[W-1]) && (res[W-1] != opnd_a[W-1]))); // R8
    AST_TRANSFER_A: assert (!(op_sel[2:0] == 3'b100 || op_sel[2:0] == 3'b111) || res == opnd_a); // R5
    AST_RSVD_PASS: assert (!op_sel[OP_RSVD_BIT] || op_sel[2:0] != 3'b100 || (res == opnd_a && !carry_out)); // R10
    AST_SUB_NOBORROW: assert (op_sel[2:0] != 3'b011 || carry_out == (opnd_a >= opnd_b)); // R4
  end
endmodule

// File: tb/steer_alu_tb_top.sv
module steer_alu_tb_top;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_sel = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] res;
  logic         carry_out, ovf, zero;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  steer_alu #(.W(W)) dut_i (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res(res), .carry_out(carry_out), .ovf(ovf), .zero(zero)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%b a=%0d b=%0d actual=%0d expected=%0d", tag, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= M/2) ? v - M : v;
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state inputs are all zero: 0 + 0 gives res 0, zero set, no carry.
    chk("R1 reset res", int'(res), 0);
    chk("R9 reset zero", int'(zero), 1);
    chk("R7 reset carry", int'(carry_out), 0);
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < M; a++) begin
        for (int b = 0; b < M; b++) begin
          int lo, cin, ey, usum, ssum, er;
          string tg;
          @(posedge clk);
          op_sel = 4'(op); opnd_a = W'(a); opnd_b = W'(b);
          @(negedge clk);
          lo  = op % 8;
          cin = lo % 2;
          case (lo)
            0: begin er = a + b;          tg = "R1"; end
            1: begin er = a + b + 1;      tg = "R2"; end
            2: begin er = a - b - 1 + M;  tg = "R3"; end
            3: begin er = a - b + M;      tg = "R4"; end
            4: begin er = a;              tg = "R5"; end
            5: begin er = a + 1;          tg = "R6"; end
            6: begin er = a - 1 + M;      tg = "R6"; end
            default: begin er = a;        tg = "R5"; end
          endcase
          er = er % M;
          if (op >= 8) tg = "R10";
          case (lo / 2)
            0: ey = b;
            1: ey = M - 1 - b;
            2: ey = 0;
            default: ey = M - 1;
          endcase
          usum = a + ey + cin;
          ssum = sgn(a) + sgn(ey) + cin;
          chk(tg, int'(res), er);
          chk(op >= 8 ? "R10 carry" : "R7 carry", int'(carry_out), (usum >= M) ? 1 : 0);
          chk(op >= 8 ? "R10 ovf" : "R8 ovf", int'(ovf), (ssum > M/2 - 1 || ssum < -M/2) ? 1 : 0);
          chk(op >= 8 ? "R10 zero" : "R9 zero", int'(zero), (er == 0) ? 1 : 0);
          if (lo == 3) chk("R4 noborrow", int'(carry_out), (a >= b) ? 1 : 0);
          if (lo == 4) chk("R5 carry100", int'(carry_out), 0);
          if (lo == 7) chk("R5 carry111", int'(carry_out), 1);
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule